// File: doc/BRIEF.md
# Calendar Clock Register File

This block is a small 32-bit register file for a real-time clock, placed in a 1 KiB address window. It keeps a packed calendar date word, a packed time-of-day word with a weekday field, a set of scratch registers, and a status word. The status word holds two sticky "update pending" flags. A one-cycle pulse on the seconds tick input moves the time forward by one second. Carries ripple through minutes, hours, weekday, day of month, month and year.

Software writes the date and time words to set the clock. Each write raises the matching pending flag in the status word. Reading the status word returns both flags and clears them. One parameter picks one of two address maps. The two maps differ in where the date and time words sit, in how many scratch registers exist and where they are, and in the base year added to the year offset when the leap-year check is made. All accesses are full 32-bit words. Read data comes back one cycle after the read strobe.

Top module: `rtc_regfile`

## Requirements
- R1: After reset every register reads 0, including the date word, the time word, the status word and all scratch registers.
- R2: Read data appears on `rd_data` in the cycle after `rd_en` is sampled high. It holds its value while `rd_en` is low.
- R3: Writing the date word sets status bit 7. Writing the time word sets status bit 8. Both bits are sticky.
- R4: A status read returns the current value, with bit 7 (date pending) and bit 8 (time pending) included, and clears both flags in the same access. Writes to the status word have no effect.
- R5: Scratch registers store any 32-bit value. Map 0 has four at 0x020, 0x024, 0x028 and 0x02C. Map 1 has eight, at 0x100 through 0x11C in steps of 4.
- R6: A read at an unmapped offset returns 0, and a write there changes nothing. This covers holes inside the map, offsets past the map, and offsets with nonzero low two bits.
- R7: Time word layout: weekday in bits 31:29 (Monday=0, Sunday=6), hour in bits 23:16, minute in bits 15:8, second in bits 7:0. On a tick the second advances and rolls from 59 to 0, carrying into the minute. The minute rolls from 59 to 0, carrying into the hour.
- R8: When a tick carries the hour past 23, the hour goes to 0, the weekday advances with 6 wrapping to 0, and the day of month advances.
- R9: Date word layout: year offset in bits 31:16, month (1-12) in bits 15:8, day (1-31) in bits 7:0. A day carry past the last day of the month sets the day to 1 and advances the month. Month 12 wraps to 1 and increments the year offset. February has 29 days when (base year + offset) is divisible by 4.
- R10: A bus write to the time word in the same cycle as a tick stores the written value, and the tick has no effect on either word. A bus write to the date word in the same cycle as a tick stores the written value, while the time word still advances.
- R11: Map 0 places status at 0x000, date at 0x004 and time at 0x008, with base year 2010. Map 1 places status at 0x000, date at 0x010 and time at 0x014, with base year 1970.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse that advances time by one second |
| bus_addr | input | 10 | Byte offset in the window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |

## Verification
The bench builds two instances side by side. One uses map 1, which has eight scratch registers and the date and time words at 0x010 and 0x014. The other uses map 0, which has four scratch registers and the date word at 0x004. With both present, one offset can be checked as a live register in one map and a hole in the other. The scratch window edge is checked in each map. Leap-year cases use year offsets 1 and 2. The two base years are congruent modulo 4, so the same offset gives the same February length in both maps.

// File: rtl/rtc_regfile_pkg.sv
package rtc_regfile_pkg;

  localparam int WORD_W        = 32;
  localparam int FLAG_DATE_BIT = 7;
  localparam int FLAG_TIME_BIT = 8;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STAT,
    SEL_DATE,
    SEL_TIME,
    SEL_SCR
  } reg_sel_e;

  // Length of a month; unknown month codes count as 31 days.
  function automatic logic [7:0] month_days(input logic [7:0] month, input logic leap);
    case (month)
      8'd4, 8'd6, 8'd9, 8'd11: month_days = 8'd30;
      8'd2:                    month_days = leap ? 8'd29 : 8'd28;
      default:                 month_days = 8'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_addr_decode.sv
module rtc_addr_decode
  import rtc_regfile_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATE_OFF = 'h004,
  parameter int TIME_OFF = 'h008,
  parameter int SCR_BASE = 'h020,
  parameter int SCR_NUM  = 4,
  parameter int IDX_W    = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [IDX_W-1:0]  scr_idx
);

  logic [SCR_NUM-1:0] scr_hit;

  // One comparator per scratch slot.
  for (genvar i = 0; i < SCR_NUM; i++) begin : g_slot
    assign scr_hit[i] = (addr == ADDR_W'(SCR_BASE + 4 * i));
  end

  always_comb begin
    scr_idx = '0;
    for (int i = 0; i < SCR_NUM; i++) begin
      if (scr_hit[i]) scr_idx = IDX_W'(i);
    end
  end

  always_comb begin
    sel = SEL_NONE;
    if (addr == ADDR_W'(0))             sel = SEL_STAT;
    else if (addr == ADDR_W'(DATE_OFF)) sel = SEL_DATE;
    else if (addr == ADDR_W'(TIME_OFF)) sel = SEL_TIME;
    else if (|scr_hit)                  sel = SEL_SCR;
  end

endmodule

// File: rtl/rtc_scratch.sv
module rtc_scratch #(
  parameter int NUM   = 4,
  parameter int IDX_W = 2,
  parameter int W     = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata
);

  logic [W-1:0] mem [NUM];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = mem[idx];

  a_r5_store: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(idx)] == $past(wdata));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_regfile_pkg::*;
#(
  parameter int BASE_YEAR = 2010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              ld_date,
  input  logic              ld_time,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] date_q,
  output logic [WORD_W-1:0] time_q
);

  logic [7:0]  sec, mins, hr, day, mon;
  logic [2:0]  wd;
  logic [15:0] yr;
  logic        sec_wrap, min_wrap, day_carry, leap, mon_end;
  logic [31:0] abs_year;
  logic [WORD_W-1:0] time_nx, date_nx;

  assign sec  = time_q[7:0];
  assign mins = time_q[15:8];
  assign hr   = time_q[23:16];
  assign wd   = time_q[31:29];
  assign day  = date_q[7:0];
  assign mon  = date_q[15:8];
  assign yr   = date_q[31:16];

  assign sec_wrap  = (sec >= 8'd59);
  assign min_wrap  = sec_wrap && (mins >= 8'd59);
  assign day_carry = min_wrap && (hr >= 8'd23);

  assign abs_year = 32'(BASE_YEAR) + {16'd0, yr};
  assign leap     = (abs_year[1:0] == 2'b00);
  assign mon_end  = (day >= month_days(mon, leap));

  always_comb begin
    time_nx        = time_q;
    time_nx[7:0]   = sec_wrap ? 8'd0 : sec + 8'd1;
    if (sec_wrap)  time_nx[15:8]  = (mins >= 8'd59) ? 8'd0 : mins + 8'd1;
    if (min_wrap)  time_nx[23:16] = (hr >= 8'd23) ? 8'd0 : hr + 8'd1;
    if (day_carry) time_nx[31:29] = (wd >= 3'd6) ? 3'd0 : wd + 3'd1;
  end

  always_comb begin
    date_nx = date_q;
    if (mon_end) begin
      date_nx[7:0] = 8'd1;
      if (mon >= 8'd12) begin
        date_nx[15:8]  = 8'd1;
        date_nx[31:16] = yr + 16'd1;
      end else begin
        date_nx[15:8]  = mon + 8'd1;
      end
    end else begin
      date_nx[7:0] = day + 8'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      time_q <= '0;
      date_q <= '0;
    end else begin
      if (ld_time)   time_q <= wdata;
      else if (tick) time_q <= time_nx;
      if (ld_date)   date_q <= wdata;
      else if (tick && day_carry && !ld_time) date_q <= date_nx;
    end
  end

  a_r7_sec_step: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld_time && time_q[7:0] < 8'd59) |=> time_q[7:0] == $past(time_q[7:0]) + 8'd1);

  a_r7_sec_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld_time && time_q[7:0] >= 8'd59) |=> time_q[7:0] == 8'd0);

  a_r8_wd_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld_time && time_q == 32'hC017_3B3B) |=> time_q == 32'h0);

  a_r10_time_load: assert property (@(posedge clk) disable iff (rst)
    ld_time |=> time_q == $past(wdata));

  a_r10_date_load: assert property (@(posedge clk) disable iff (rst)
    ld_date |=> date_q == $past(wdata));

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_regfile_pkg::*;
#(
  parameter int MAP_SEL = 1,
  parameter int ADDR_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_re,
  output logic [31:0]       rd_data
);

  localparam int DATE_OFF  = (MAP_SEL == 0) ? 'h004 : 'h010;
  localparam int TIME_OFF  = (MAP_SEL == 0) ? 'h008 : 'h014;
  localparam int SCR_BASE  = (MAP_SEL == 0) ? 'h020 : 'h100;
  localparam int SCR_NUM   = (MAP_SEL == 0) ? 4 : 8;
  localparam int BASE_YEAR = (MAP_SEL == 0) ? 2010 : 1970;
  localparam int IDX_W     = $clog2(SCR_NUM);

  reg_sel_e          sel;
  logic [IDX_W-1:0]  scr_idx;
  logic [WORD_W-1:0] scr_rdata, date_q, time_q, stat_word;
  logic              flag_date, flag_time;
  logic              wr_date, wr_time, rd_stat;

  rtc_addr_decode #(
    .ADDR_W(ADDR_W), .DATE_OFF(DATE_OFF), .TIME_OFF(TIME_OFF),
    .SCR_BASE(SCR_BASE), .SCR_NUM(SCR_NUM), .IDX_W(IDX_W)
  ) u_dec (
    .addr(bus_addr), .sel(sel), .scr_idx(scr_idx)
  );

  rtc_scratch #(.NUM(SCR_NUM), .IDX_W(IDX_W), .W(WORD_W)) u_scr (
    .clk(clk), .rst(rst), .we(bus_we && sel == SEL_SCR),
    .idx(scr_idx), .wdata(bus_wdata), .rdata(scr_rdata)
  );

  assign wr_date = bus_we && (sel == SEL_DATE);
  assign wr_time = bus_we && (sel == SEL_TIME);
  assign rd_stat = bus_re && (sel == SEL_STAT);

  rtc_calendar #(.BASE_YEAR(BASE_YEAR)) u_cal (
    .clk(clk), .rst(rst), .tick(sec_tick),
    .ld_date(wr_date), .ld_time(wr_time), .wdata(bus_wdata),
    .date_q(date_q), .time_q(time_q)
  );

  always_comb begin
    stat_word = '0;
    stat_word[FLAG_DATE_BIT] = flag_date;
    stat_word[FLAG_TIME_BIT] = flag_time;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_date <= 1'b0;
      flag_time <= 1'b0;
    end else begin
      if (rd_stat) begin
        flag_date <= 1'b0;
        flag_time <= 1'b0;
      end
      if (wr_date) flag_date <= 1'b1;
      if (wr_time) flag_time <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (bus_re) begin
      case (sel)
        SEL_STAT: rd_data <= stat_word;
        SEL_DATE: rd_data <= date_q;
        SEL_TIME: rd_data <= time_q;
        SEL_SCR:  rd_data <= scr_rdata;
        default:  rd_data <= '0;
      endcase
    end
  end

  a_r3_date_flag: assert property (@(posedge clk) disable iff (rst)
    wr_date |=> flag_date);

  a_r3_time_flag: assert property (@(posedge clk) disable iff (rst)
    wr_time |=> flag_time);

  a_r4_clear: assert property (@(posedge clk) disable iff (rst)
    rd_stat |=> !flag_date && !flag_time);

  a_r6_hole_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_re && sel == SEL_NONE) |=> rd_data == 32'h0);

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!bus_re && !$past(rst)) |=> $stable(rd_data));

endmodule

// File: tb/tb_rtc_regfile.sv
`timescale 1ns/1ps
module tb_rtc_regfile;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  // index 0: map 0 (dut_alt), index 1: map 1 (dut)
  logic [9:0]  addr_s [2];
  logic        we_s   [2];
  logic        re_s   [2];
  logic [31:0] wd_s   [2];
  logic        tk_s   [2];
  logic [31:0] rd_b, rd_a;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  rtc_regfile #(.MAP_SEL(1)) dut (
    .clk(clk), .rst(rst), .sec_tick(tk_s[1]), .bus_addr(addr_s[1]),
    .bus_we(we_s[1]), .bus_wdata(wd_s[1]), .bus_re(re_s[1]), .rd_data(rd_b)
  );

  rtc_regfile #(.MAP_SEL(0)) dut_alt (
    .clk(clk), .rst(rst), .sec_tick(tk_s[0]), .bus_addr(addr_s[0]),
    .bus_we(we_s[0]), .bus_wdata(wd_s[0]), .bus_re(re_s[0]), .rd_data(rd_a)
  );

  task automatic idle();
    for (int v = 0; v < 2; v++) begin
      addr_s[v] = '0; we_s[v] = 1'b0; re_s[v] = 1'b0; wd_s[v] = '0; tk_s[v] = 1'b0;
    end
  endtask

  task automatic drv(input int v, input logic [9:0] ad, input logic we,
                     input logic re, input logic [31:0] wd, input logic tk);
    @(negedge clk);
    addr_s[v] = ad; we_s[v] = we; re_s[v] = re; wd_s[v] = wd; tk_s[v] = tk;
    @(negedge clk);
    idle();
  endtask

  task automatic wr(input int v, input logic [9:0] ad, input logic [31:0] d);
    drv(v, ad, 1'b1, 1'b0, d, 1'b0);
  endtask

  task automatic rd(input int v, input logic [9:0] ad, output logic [31:0] d);
    drv(v, ad, 1'b0, 1'b1, 32'h0, 1'b0);
    d = (v == 0) ? rd_a : rd_b;
  endtask

  task automatic tick(input int v);
    drv(v, 10'h0, 1'b0, 1'b0, 32'h0, 1'b1);
  endtask

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic rd_check(input int v, input logic [9:0] ad, input logic [31:0] exp, input string what);
    logic [31:0] d;
    rd(v, ad, d);
    check(what, d, exp);
  endtask

  task automatic t_reset();
    check("R1 rd_data after reset", rd_b, 32'h0);
    rd_check(1, 10'h000, 32'h0, "R1 status reset");
    rd_check(1, 10'h010, 32'h0, "R1 date reset");
    rd_check(1, 10'h014, 32'h0, "R1 time reset");
    rd_check(1, 10'h11C, 32'h0, "R1 scratch reset");
    rd_check(0, 10'h004, 32'h0, "R1 map0 date reset");
  endtask

  task automatic t_flags();
    wr(1, 10'h010, 32'h0001_0203);
    rd_check(1, 10'h000, 32'h0000_0080, "R3 date flag");
    rd_check(1, 10'h000, 32'h0, "R4 status cleared by read");
    wr(1, 10'h014, 32'h0001_0203);
    rd_check(1, 10'h000, 32'h0000_0100, "R3 time flag");
    wr(1, 10'h010, 32'h0);
    wr(1, 10'h014, 32'h0);
    rd_check(1, 10'h000, 32'h0000_0180, "R4 both flags");
    wr(1, 10'h000, 32'hFFFF_FFFF);
    rd_check(1, 10'h000, 32'h0, "R4 status write ignored");
  endtask

  task automatic t_scratch();
    for (int i = 0; i < 8; i++) wr(1, 10'(10'h100 + 4 * i), 32'hA5A5_0000 + 32'(i));
    for (int i = 0; i < 8; i++) rd_check(1, 10'(10'h100 + 4 * i), 32'hA5A5_0000 + 32'(i), "R5 map1 scratch");
    for (int i = 0; i < 4; i++) wr(0, 10'(10'h020 + 4 * i), 32'h5A00_0000 + 32'(i));
    wr(0, 10'h030, 32'hDEAD_BEEF);
    rd_check(0, 10'h030, 32'h0, "R6 map0 past scratch window");
    for (int i = 0; i < 4; i++) rd_check(0, 10'(10'h020 + 4 * i), 32'h5A00_0000 + 32'(i), "R5 map0 scratch");
    wr(1, 10'h120, 32'h1234_5678);
    rd_check(1, 10'h120, 32'h0, "R6 map1 past scratch window");
  endtask

  task automatic t_unmapped();
    rd_check(1, 10'h004, 32'h0, "R11 map1 offset 0x004 is hole");
    wr(1, 10'h0F0, 32'hFFFF_FFFF);
    rd_check(1, 10'h0F0, 32'h0, "R6 hole write");
    wr(1, 10'h010, 32'h0007_0809);
    rd_check(1, 10'h000, 32'h0000_0080, "R3 flag before misaligned");
    wr(1, 10'h011, 32'hFFFF_FFFF);
    rd_check(1, 10'h010, 32'h0007_0809, "R6 misaligned write no effect");
    rd_check(1, 10'h000, 32'h0, "R6 misaligned write no flag");
    rd_check(1, 10'h3FC, 32'h0, "R6 top of window");
  endtask

  task automatic t_variant_a();
    wr(0, 10'h004, 32'h0003_0405);
    wr(0, 10'h008, 32'h0001_0203);
    rd_check(0, 10'h004, 32'h0003_0405, "R11 map0 date at 0x004");
    rd_check(0, 10'h008, 32'h0001_0203, "R11 map0 time at 0x008");
    rd_check(0, 10'h000, 32'h0000_0180, "R11 map0 status at 0x000");
    rd_check(0, 10'h010, 32'h0, "R11 map0 offset 0x010 is hole");
  endtask

  task automatic t_time_roll();
    wr(1, 10'h014, 32'h400A_3B3B);
    tick(1);
    rd_check(1, 10'h014, 32'h400B_0000, "R7 second/minute carry into hour");
    wr(1, 10'h014, 32'h0000_0105);
    tick(1);
    rd_check(1, 10'h014, 32'h0000_0106, "R7 plain second step");
    tick(1);
    rd_check(1, 10'h014, 32'h0000_0107, "R7 second step twice");
  endtask

  task automatic day_roll(input int v, input logic [9:0] da, input logic [9:0] ta,
                          input logic [31:0] d0, input logic [31:0] t0,
                          input logic [31:0] d1, input logic [31:0] t1, input string what);
    wr(v, ta, t0);
    wr(v, da, d0);
    tick(v);
    rd_check(v, da, d1, what);
    rd_check(v, ta, t1, what);
  endtask

  task automatic t_day_roll();
    day_roll(1, 10'h010, 10'h014, 32'h0005_011F, 32'hC017_3B3B, 32'h0005_0201, 32'h0000_0000, "R8 weekday wrap Jan31");
    day_roll(1, 10'h010, 10'h014, 32'h0005_0305, 32'h4017_3B3B, 32'h0005_0306, 32'h6000_0000, "R8 mid-month day step");
  endtask

  task automatic t_month_roll();
    day_roll(1, 10'h010, 10'h014, 32'h0003_0C1F, 32'h0017_3B3B, 32'h0004_0101, 32'h2000_0000, "R9 year wrap");
    day_roll(1, 10'h010, 10'h014, 32'h0001_041E, 32'h0017_3B3B, 32'h0001_0501, 32'h2000_0000, "R9 30-day month");
    day_roll(1, 10'h010, 10'h014, 32'h0002_021C, 32'h0017_3B3B, 32'h0002_021D, 32'h2000_0000, "R9 leap Feb 1972");
    day_roll(1, 10'h010, 10'h014, 32'h0001_021C, 32'h0017_3B3B, 32'h0001_0301, 32'h2000_0000, "R9 common Feb 1971");
    day_roll(0, 10'h004, 10'h008, 32'h0002_021C, 32'h0017_3B3B, 32'h0002_021D, 32'h2000_0000, "R9 map0 leap Feb 2012");
    day_roll(0, 10'h004, 10'h008, 32'h0003_021C, 32'h0017_3B3B, 32'h0003_0301, 32'h2000_0000, "R9 map0 common Feb 2013");
  endtask

  task automatic t_priority();
    wr(1, 10'h010, 32'h0005_011F);
    wr(1, 10'h014, 32'h0017_3B3B);
    drv(1, 10'h014, 1'b1, 1'b0, 32'h0017_3B3B, 1'b1);
    rd_check(1, 10'h014, 32'h0017_3B3B, "R10 time write beats tick");
    rd_check(1, 10'h010, 32'h0005_011F, "R10 no day carry under time write");
    drv(1, 10'h010, 1'b1, 1'b0, 32'h0009_0A0B, 1'b1);
    rd_check(1, 10'h010, 32'h0009_0A0B, "R10 date write beats carry");
    rd_check(1, 10'h014, 32'h2000_0000, "R10 time advances with date write");
  endtask

  task automatic t_hold();
    logic [31:0] d;
    rd(1, 10'h104, d);
    check("R2 read value", d, 32'hA5A5_0001);
    wr(1, 10'h104, 32'h0);
    tick(1);
    repeat (3) @(negedge clk);
    check("R2 rd_data holds without read", rd_b, 32'hA5A5_0001);
  endtask

  initial begin
    idle();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_flags();
    t_scratch();
    t_unmapped();
    t_variant_a();
    t_time_roll();
    t_day_roll();
    t_month_roll();
    t_priority();
    t_hold();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule